// File: doc/BRIEF.md
# Capture/Compare PWM Channel

This block is one channel of a multi-channel timer array. It watches a shared 16-bit timebase count, the overflow/limit pulse of that count and one external input pin. From these it drives one output pin and keeps two sticky interrupt flags: a match/capture flag and an intermediate-overflow flag. The channel runs in one of five modes: edge PWM, center PWM, high-frequency square wave, timer/capture, and PWM with a narrower width of n bits.

Software never writes the active compare register directly. It writes a staging register, and the staged value moves into the active register on the next timebase overflow/limit pulse. A pending status tracks the move. When the channel sees an output event, it applies one of four actions chosen per channel: toggle, set, clear or hold. In capture mode, a synchronized edge on the input pin copies the current count into the compare register. The bus interface, the counter and its prescaler are outside this block. Configuration and the single-cycle software strobes arrive as plain ports.

Top module: `ccp_channel`

## Requirements
- R1: After reset, out_o, cmp_o, upd_pend_o, cci_flag_o, iovf_flag_o and irq_o are all 0.
- R2: A cycle with upd_wr_i high stores upd_data_i and sets upd_pend_o at the next edge. While pending, a cycle with cnt_ovf_i high moves the stored value into cmp_o and clears upd_pend_o. This happens unless a capture occurs in the same cycle, or a new write occurs in the same cycle. A write in the same cycle as the overflow pulse moves the value stored earlier and leaves the new value pending.
- R3: out_fn_i encodes the output action: 0 toggles out_o, 1 sets it to 1, 2 clears it to 0, 3 holds it. The action is applied once per cycle in which at least one output event occurs.
- R4: A match is an arrival: cnt_i differs from its value in the previous cycle and equals the compare value (cmp_o[15:0], or its low n bits in mode 4). Mode 0 (edge PWM) has two output events: a match, and a cycle with cnt_ovf_i high.
- R5: In mode 1 (center PWM), only a match is an output event. cnt_ovf_i does not change out_o.
- R6: In mode 2 (square wave), a match is an output event, and it adds cmp_o[15:8] to cmp_o[7:0] modulo 256, with bits 17:8 unchanged. An update transfer in the same cycle takes priority over the add.
- R7: In mode 3 (timer/capture), cap_pin_i passes through two synchronizer flops before edge detection. Captures take effect at the third clock edge after the pin is first sampled at its new level. rise_en_i enables capture on rising edges and fall_en_i enables it on falling edges. A capture loads {2'b00, cnt_i} into cmp_o and is an output event, and a match is also an output event. A capture takes priority over an update transfer, and the pending state is kept.
- R8: In mode 4 (n-bit PWM), n = nbits_i + 1, and a match compares the low n bits. An intermediate overflow occurs when cnt_i changes and its low n bits become 0. It sets iovf_flag_o and is an output event. cnt_ovf_i is not an output event in this mode.
- R9: cci_flag_o is set by any match (in modes 0 to 4) or any capture. iovf_flag_o is set only in mode 4.
- R10: A cycle with clr_cci_i or clr_iovf_i high clears the flag it names. If a set occurs in the same cycle, the set wins.
- R11: irq_o = (cci_flag_o & cci_en_i) | (iovf_flag_o & iovf_en_i), without any clock delay.
- R12: Mode codes 5 to 7 produce no events: out_o holds and no flag is set. The update transfer still works.
- R13: While cnt_i holds its value for several cycles, a match fires only once, in the cycle the count arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Shared timebase count |
| cnt_ovf_i | input | 1 | Timebase overflow/limit pulse |
| cap_pin_i | input | 1 | Asynchronous capture input pin |
| mode_i | input | 3 | Channel mode (0 edge, 1 center, 2 square, 3 capture, 4 n-bit) |
| out_fn_i | input | 2 | Output action on event |
| nbits_i | input | 4 | n-bit width minus one |
| rise_en_i | input | 1 | Capture on rising edge |
| fall_en_i | input | 1 | Capture on falling edge |
| cci_en_i | input | 1 | Match/capture interrupt enable |
| iovf_en_i | input | 1 | Intermediate-overflow interrupt enable |
| upd_wr_i | input | 1 | Write strobe for the staging register |
| upd_data_i | input | 18 | Staged compare value |
| clr_cci_i | input | 1 | Clear strobe for cci_flag_o |
| clr_iovf_i | input | 1 | Clear strobe for iovf_flag_o |
| out_o | output | 1 | Channel output pin state |
| cmp_o | output | 18 | Active compare / captured value |
| upd_pend_o | output | 1 | Staged value not yet transferred |
| cci_flag_o | output | 1 | Match/capture flag |
| iovf_flag_o | output | 1 | Intermediate-overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
In every cycle, the bench compares all six outputs with a behavioural model.

The stimulus exercises each behaviour in turn:
- **Free-running counts:** an up-counter wraps at several limits. Under each of the four output actions, this separates the edge, center and reserved modes by whether the overflow pulse moves the output.
- **Held counts:** a counter that holds each value for three cycles exposes any match that fires again on a stale count.
- **Square wave:** a run with a large limit checks the low-byte stepping.
- **Capture:** a pin toggling at odd intervals, under each combination of edge enables, checks polarity selection and the synchronizer latency.
- **N-bit mode:** a narrow width checks the low-bit match and the intermediate-overflow flag.
- **Strobe timing:** writes and clears placed on overflow or event cycles check the stated priorities.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  typedef enum logic [2:0] {
    MODE_EDGE    = 3'd0,
    MODE_CENTER  = 3'd1,
    MODE_SQUARE  = 3'd2,
    MODE_CAPTURE = 3'd3,
    MODE_NBIT    = 3'd4
  } ccp_mode_e;

  typedef enum logic [1:0] {
    FN_TOGGLE = 2'd0,
    FN_SET    = 2'd1,
    FN_CLEAR  = 2'd2,
    FN_HOLD   = 2'd3
  } ccp_fn_e;

  function automatic logic apply_fn(input logic cur, input logic [1:0] fn);
    case (ccp_fn_e'(fn))
      FN_TOGGLE: return ~cur;
      FN_SET:    return 1'b1;
      FN_CLEAR:  return 1'b0;
      default:   return cur;
    endcase
  endfunction
endpackage

// File: rtl/ccp_edge_sync.sv
module ccp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= pin_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/ccp_event_gen.sv
module ccp_event_gen
  import ccp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NB_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_ovf_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [2:0]       mode_i,
  input  logic [NB_W-1:0]  nbits_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             rise_en_i,
  input  logic             fall_en_i,
  output logic             match_o,
  output logic             cap_o,
  output logic             iovf_o,
  output logic             out_evt_o
);
  localparam logic [NB_W-1:0] TOP_SH = NB_W'(CNT_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic [NB_W-1:0]  sh;
  logic             arrive, eq_full, eq_part;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_i;
  end

  assign sh      = TOP_SH - nbits_i;
  assign mask    = {CNT_W{1'b1}} >> sh;
  assign arrive  = (cnt_i != cnt_q);
  assign eq_full = (cnt_i == cmp_i);
  assign eq_part = ((cnt_i & mask) == (cmp_i & mask));

  always_comb begin
    match_o   = 1'b0;
    cap_o     = 1'b0;
    iovf_o    = 1'b0;
    out_evt_o = 1'b0;
    case (mode_i)
      MODE_EDGE: begin
        match_o   = arrive & eq_full;
        out_evt_o = match_o | cnt_ovf_i;
      end
      MODE_CENTER, MODE_SQUARE: begin
        match_o   = arrive & eq_full;
        out_evt_o = match_o;
      end
      MODE_CAPTURE: begin
        match_o   = arrive & eq_full;
        cap_o     = (rise_i & rise_en_i) | (fall_i & fall_en_i);
        out_evt_o = match_o | cap_o;
      end
      MODE_NBIT: begin
        match_o   = arrive & eq_part;
        iovf_o    = arrive & ((cnt_i & mask) == '0);
        out_evt_o = match_o | iovf_o;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ccp_cmp_reg.sv
module ccp_cmp_reg #(
  parameter int CNT_W = 16,
  parameter int CMP_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CMP_W-1:0] wr_data_i,
  input  logic             xfer_i,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cap_val_i,
  input  logic             step_i,
  output logic [CMP_W-1:0] cmp_o,
  output logic             pend_o
);
  localparam int HALF_W = CNT_W / 2;

  logic [CMP_W-1:0]  upd_q, cmp_q, cmp_d;
  logic              pend_q;
  logic [HALF_W-1:0] low_sum;

  assign low_sum = cmp_q[HALF_W-1:0] + cmp_q[CNT_W-1:HALF_W];

  always_comb begin
    cmp_d = cmp_q;
    if (cap_i)                cmp_d = CMP_W'(cap_val_i);
    else if (xfer_i && pend_q) cmp_d = upd_q;
    else if (step_i)          cmp_d = {cmp_q[CMP_W-1:HALF_W], low_sum};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q  <= '0;
      cmp_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      if (wr_i) begin
        upd_q  <= wr_data_i;
        pend_q <= 1'b1;
      end else if (xfer_i && !cap_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign cmp_o  = cmp_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
  import ccp_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int CMP_W   = 18,
  parameter int NB_W    = 4,
  parameter int SYNC_ST = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cnt_ovf_i,
  input  logic             cap_pin_i,
  input  logic [2:0]       mode_i,
  input  logic [1:0]       out_fn_i,
  input  logic [NB_W-1:0]  nbits_i,
  input  logic             rise_en_i,
  input  logic             fall_en_i,
  input  logic             cci_en_i,
  input  logic             iovf_en_i,
  input  logic             upd_wr_i,
  input  logic [CMP_W-1:0] upd_data_i,
  input  logic             clr_cci_i,
  input  logic             clr_iovf_i,
  output logic             out_o,
  output logic [CMP_W-1:0] cmp_o,
  output logic             upd_pend_o,
  output logic             cci_flag_o,
  output logic             iovf_flag_o,
  output logic             irq_o
);
  logic rise, fall, match, cap, iovf_evt, out_evt, step;
  logic out_q, cci_q, iovf_q;

  ccp_edge_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .pin_i(cap_pin_i),
    .rise_o(rise),  .fall_o(fall)
  );

  ccp_event_gen #(.CNT_W(CNT_W), .NB_W(NB_W)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt_i),
    .cnt_ovf_i(cnt_ovf_i),
    .cmp_i    (cmp_o[CNT_W-1:0]),
    .mode_i   (mode_i),
    .nbits_i  (nbits_i),
    .rise_i   (rise),
    .fall_i   (fall),
    .rise_en_i(rise_en_i),
    .fall_en_i(fall_en_i),
    .match_o  (match),
    .cap_o    (cap),
    .iovf_o   (iovf_evt),
    .out_evt_o(out_evt)
  );

  assign step = match & (mode_i == MODE_SQUARE);

  ccp_cmp_reg #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (upd_wr_i),
    .wr_data_i(upd_data_i),
    .xfer_i   (cnt_ovf_i),
    .cap_i    (cap),
    .cap_val_i(cnt_i),
    .step_i   (step),
    .cmp_o    (cmp_o),
    .pend_o   (upd_pend_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= 1'b0;
      cci_q  <= 1'b0;
      iovf_q <= 1'b0;
    end else begin
      if (out_evt)               out_q  <= apply_fn(out_q, out_fn_i);
      if (match || cap)          cci_q  <= 1'b1;
      else if (clr_cci_i)        cci_q  <= 1'b0;
      if (iovf_evt)              iovf_q <= 1'b1;
      else if (clr_iovf_i)       iovf_q <= 1'b0;
    end
  end

  assign out_o       = out_q;
  assign cci_flag_o  = cci_q;
  assign iovf_flag_o = iovf_q;
  assign irq_o       = (cci_q & cci_en_i) | (iovf_q & iovf_en_i);
endmodule

// File: rtl/ccp_channel_chk.sv
module ccp_channel_chk #(
  parameter int CMP_W = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_ovf_i,
  input logic [2:0]       mode_i,
  input logic [1:0]       out_fn_i,
  input logic             upd_wr_i,
  input logic             clr_cci_i,
  input logic             out_o,
  input logic [CMP_W-1:0] cmp_o,
  input logic             upd_pend_o,
  input logic             cci_flag_o,
  input logic             iovf_flag_o
);
  p_pend_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_wr_i |=> upd_pend_o);

  p_cmp_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_ovf_i && mode_i != 3'd2 && mode_i != 3'd3) |=> $stable(cmp_o));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_fn_i == 2'd3) |=> $stable(out_o));

  p_iovf_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 3'd4 && !iovf_flag_o) |=> !iovf_flag_o);

  p_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_cci_i && mode_i >= 3'd5) |=> !cci_flag_o);

  p_reserved_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i >= 3'd5) |=> $stable(out_o));
endmodule

bind ccp_channel ccp_channel_chk #(.CMP_W(CMP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_ovf_i  (cnt_ovf_i),
  .mode_i     (mode_i),
  .out_fn_i   (out_fn_i),
  .upd_wr_i   (upd_wr_i),
  .clr_cci_i  (clr_cci_i),
  .out_o      (out_o),
  .cmp_o      (cmp_o),
  .upd_pend_o (upd_pend_o),
  .cci_flag_o (cci_flag_o),
  .iovf_flag_o(iovf_flag_o)
);

// File: tb/ccp_channel_test.sv
`timescale 1ns/1ps
module ccp_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_i = '0;
  logic        ovf_i = 1'b0, pin_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  fn_i = '0;
  logic [3:0]  nb_i = '0;
  logic        ren_i = 1'b0, fen_i = 1'b0, cen_i = 1'b0, ien_i = 1'b0;
  logic        wr_i = 1'b0, clrc_i = 1'b0, clri_i = 1'b0;
  logic [17:0] wdat_i = '0;
  logic        out_o, pend_o, cci_o, iovf_o, irq_o;
  logic [17:0] cmp_o;

  ccp_channel uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt_i), .cnt_ovf_i(ovf_i),
    .cap_pin_i(pin_i), .mode_i(mode_i), .out_fn_i(fn_i), .nbits_i(nb_i),
    .rise_en_i(ren_i), .fall_en_i(fen_i), .cci_en_i(cen_i), .iovf_en_i(ien_i),
    .upd_wr_i(wr_i), .upd_data_i(wdat_i), .clr_cci_i(clrc_i), .clr_iovf_i(clri_i),
    .out_o(out_o), .cmp_o(cmp_o), .upd_pend_o(pend_o), .cci_flag_o(cci_o),
    .iovf_flag_o(iovf_o), .irq_o(irq_o)
  );

  always #2.5 clk = ~clk;

  int    vectors = 0, errors = 0;
  string req = "R1";
  bit    done = 1'b0;

  // reference model state
  int m_out, m_cmp, m_upd, m_pend, m_cci, m_iovf, m_cntq, m_s1, m_s2, m_s3;
  // bench counter
  int cnt = 0, lim = 15, hold = 1, tickc = 0;

  task automatic chk(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    int adv, arrive, mask, rise, fall, cap, match, iv, oev, n_out, n_cmp, n_pend;
    adv   = (tickc % hold) == 0;
    cnt_i = 16'(cnt);
    ovf_i = adv && (cnt == lim);
    arrive = (cnt != m_cntq);
    mask  = (1 << (int'(nb_i) + 1)) - 1;
    rise  = m_s2 && !m_s3;
    fall  = !m_s2 && m_s3;
    cap   = (mode_i == 3) && ((rise && ren_i) || (fall && fen_i));
    if (mode_i <= 3)      match = arrive && (cnt == (m_cmp & 16'hFFFF));
    else if (mode_i == 4) match = arrive && ((cnt & mask) == (m_cmp & mask));
    else                  match = 0;
    iv  = (mode_i == 4) && arrive && ((cnt & mask) == 0);
    oev = match || cap || (mode_i == 0 && ovf_i) || iv;
    n_out = m_out;
    if (oev) begin
      if (fn_i == 0) n_out = !m_out;
      else if (fn_i == 1) n_out = 1;
      else if (fn_i == 2) n_out = 0;
    end
    n_cmp = m_cmp;
    if (cap) n_cmp = cnt;
    else if (ovf_i && m_pend) n_cmp = m_upd;
    else if (mode_i == 2 && match)
      n_cmp = (m_cmp & 'h3FF00) | (((m_cmp & 'hFF) + ((m_cmp >> 8) & 'hFF)) & 'hFF);
    n_pend = m_pend;
    if (wr_i) n_pend = 1; else if (ovf_i && !cap) n_pend = 0;
    @(posedge clk);
    #1;
    m_out = n_out; m_cmp = n_cmp; m_pend = n_pend;
    if (wr_i) m_upd = int'(wdat_i);
    if (match || cap) m_cci = 1; else if (clrc_i) m_cci = 0;
    if (iv) m_iovf = 1; else if (clri_i) m_iovf = 0;
    m_cntq = cnt; m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_i;
    chk("out_o", out_o, m_out);
    chk("cmp_o", cmp_o, m_cmp);
    chk("upd_pend_o", pend_o, m_pend);
    chk("cci_flag_o", cci_o, m_cci);
    chk("iovf_flag_o", iovf_o, m_iovf);
    chk("irq_o", irq_o, (m_cci && cen_i) || (m_iovf && ien_i));
    if (adv) cnt = (cnt >= lim) ? 0 : cnt + 1;
    tickc++;
  endtask

  task automatic wr(int v);
    wr_i = 1'b1; wdat_i = 18'(v); step(); wr_i = 1'b0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      clrc_i = (i % 37) == 36;
      clri_i = (i % 41) == 40;
      step();
    end
    clrc_i = 1'b0; clri_i = 1'b0;
  endtask

  task automatic wait_ovf();
    // leaves the next step on the overflow cycle
    while (!((cnt == lim) && ((tickc % hold) == 0))) step();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    m_out = 0; m_cmp = 0; m_upd = 0; m_pend = 0; m_cci = 0; m_iovf = 0;
    m_cntq = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    repeat (3) @(posedge clk);
    #1;
    req = "R1";
    chk("out_o", out_o, 0); chk("cmp_o", cmp_o, 0); chk("upd_pend_o", pend_o, 0);
    chk("cci_flag_o", cci_o, 0); chk("iovf_flag_o", iovf_o, 0); chk("irq_o", irq_o, 0);
    rst_n = 1'b1;
    run(4);

    req = "R2"; mode_i = 3'd0; fn_i = 2'd0; cen_i = 1'b1;
    wr(5); run(40);
    wr(9); wait_ovf(); wr(3); run(3); wait_ovf(); run(20);

    req = "R4";
    for (int f = 0; f < 4; f++) begin
      fn_i = 2'(f); run(40);
    end
    req = "R3"; fn_i = 2'd3; run(30); fn_i = 2'd0;

    req = "R5"; mode_i = 3'd1; lim = 11; wr(7);
    for (int f = 0; f < 4; f++) begin
      fn_i = 2'(f); run(36);
    end

    req = "R13"; hold = 3; mode_i = 3'd0; fn_i = 2'd0; run(120); hold = 1;

    req = "R6"; mode_i = 3'd2; lim = 1023; cen_i = 1'b0; wr('h0305);
    wait_ovf(); step(); run(1100);
    wr('h1010); wait_ovf(); run(200);

    req = "R7"; mode_i = 3'd3; lim = 200; cen_i = 1'b1;
    for (int e = 0; e < 4; e++) begin
      ren_i = e[0]; fen_i = e[1];
      for (int i = 0; i < 90; i++) begin
        pin_i = ((i / 7) % 2) == 1;
        if (i == 30) wr('h2ABC); else step();
      end
    end
    pin_i = 1'b0; ren_i = 1'b1; fen_i = 1'b1; run(10);

    req = "R8"; mode_i = 3'd4; nb_i = 4'd3; lim = 63; ien_i = 1'b1; wr(6);
    for (int f = 0; f < 3; f++) begin
      fn_i = 2'(f); run(70);
    end
    nb_i = 4'd15; wr(40); run(140);

    req = "R10"; nb_i = 4'd2;
    for (int i = 0; i < 64; i++) begin
      clrc_i = 1'b1; clri_i = i[0]; step();
    end
    clrc_i = 1'b0; clri_i = 1'b0;

    req = "R11"; cen_i = 1'b0; run(20); ien_i = 1'b0; cen_i = 1'b1; run(20);

    req = "R9"; mode_i = 3'd1; clri_i = 1'b1; step(); clri_i = 1'b0; run(40);

    req = "R12"; lim = 15;
    for (int md = 5; md < 8; md++) begin
      mode_i = 3'(md); fn_i = 2'd0;
      clrc_i = 1'b1; step(); clrc_i = 1'b0;
      wr(md); run(40);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule